// File: doc/BRIEF.md
# Serial DAC Load Sequencer

This block drives the three control lines of a 12-bit, serial-input, double-buffered DAC from the system clock. These lines are a serial clock, a serial data line and an active-low load strobe. A parallel code arrives on a valid/ready handshake. In bipolar mode the block maps a two's-complement code to offset binary as the code is accepted. The word then leaves most significant bit first, and the receiver captures each bit on a rising serial-clock edge. When the last bit is in, a single low pulse on the load strobe moves the word into the converter's output register.

Each interface phase lasts a whole number of system-clock cycles. The setup time, hold time, clock-high width, clock-low width and load-pulse width are separate parameters. Each gives the minimum duration of its phase, rounded up to whole cycles. The serial clock rests low between words. The data line moves only while the clock is low. A word offered while a transfer is running waits at the handshake until the current transfer ends.

Top module: `dac_serial_loader`

## Requirements
- R1: A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls on the next cycle and stays low while `sclk` is high or `load_n` is low. It returns high in the same cycle that `load_n` returns high.
- R2: Each word goes out as exactly 12 bits, bit 11 first and bit 0 last. Each bit is presented on `sdata` and captured at a rising edge of `sclk`.
- R3: With `in_bipolar` = 1 at acceptance, the transmitted word is `in_code` with only bit 11 inverted (0x800 goes out as 0x000, 0x7FF as 0xFFF, 0x555 as 0xD55). With `in_bipolar` = 0 the code goes out unchanged.
- R4: `in_code` and `in_bipolar` are sampled only at acceptance. Changes to them during a transfer do not alter the transmitted word.
- R5: `sdata` holds its value for at least SETUP_CYC cycles before each rising edge of `sclk`. It changes only when `sclk` is low in both the current cycle and the previous cycle.
- R6: `sdata` holds its value for at least HOLD_CYC cycles, counted from each rising edge of `sclk`.
- R7: Every high phase of `sclk` lasts at least HIGH_CYC cycles. Every low phase between two bits lasts at least LOW_CYC cycles. `sclk` is low whenever the block is idle.
- R8: After the high phase of the 12th bit, `load_n` goes low once for at least LOAD_CYC cycles while `sclk` stays low. `load_n` is high at all other times.
- R9: A word offered while a transfer is running is held off and not lost. It is sent after the running word, in order.
- R10: A synchronous reset abandons any transfer without a load pulse. From the next cycle, `sclk` is 0, `load_n` is 1, `sdata` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | Sequencer can accept a code |
| in_code | input | 12 | Code to convert |
| in_bipolar | input | 1 | 1: treat code as two's complement and send offset binary |
| sclk | output | 1 | Serial clock to the converter, idles low |
| sdata | output | 1 | Serial data, most significant bit first |
| load_n | output | 1 | Active-low strobe that transfers the shifted word |

## Verification
The assertions assume that `in_valid`, `in_code` and `in_bipolar` change only between clock edges, and that reset stays high for at least one edge at start-up. They assume no other constraint on the inputs. In particular, they do not require `in_valid` to be held until acceptance or the code to be stable during a transfer. The stimulus drives every input on the falling edge. It deliberately changes the code and the mode right after acceptance, keeps `in_valid` high across a running transfer, and asserts reset mid-word, so all these conditions stay inside what the assertions allow.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOWHOLD,
    ST_LOWSET,
    ST_LOAD
  } seq_state_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_code_map.sv
module dac_code_map #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              bipolar,
  input  logic [WORD_W-1:0] code_in,
  output logic [WORD_W-1:0] code_out
);
  // offset binary from two's complement: flip the sign bit only
  always_comb begin
    code_out = code_in;
    if (bipolar) code_out[WORD_W-1] = ~code_in[WORD_W-1];
  end
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ld)          cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/dac_shift_out.sv
module dac_shift_out #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              shift,
  output logic              msb
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '0;
    else if (load)  shreg <= din;
    else if (shift) shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  assign msb = shreg[WORD_W-1];
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
  import dac_seq_pkg::*;
#(
  parameter int unsigned WORD_W    = 12,
  parameter int unsigned SETUP_CYC = 4,
  parameter int unsigned HOLD_CYC  = 8,
  parameter int unsigned HIGH_CYC  = 9,
  parameter int unsigned LOW_CYC   = 12,
  parameter int unsigned LOAD_CYC  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_code,
  input  logic              in_bipolar,
  output logic              sclk,
  output logic              sdata,
  output logic              load_n
);
  // phase lengths in cycles, each at least one
  localparam int unsigned HIGH_LEN = umax(HIGH_CYC, 1);
  localparam int unsigned HOLD_LEN = umax((HOLD_CYC > HIGH_LEN) ? HOLD_CYC - HIGH_LEN : 0, 1);
  localparam int unsigned SET_LEN  = umax(umax(SETUP_CYC, (LOW_CYC > HOLD_LEN) ? LOW_CYC - HOLD_LEN : 0), 1);
  localparam int unsigned LEAD_LEN = umax(umax(SETUP_CYC, LOW_CYC), 1);
  localparam int unsigned LOAD_LEN = umax(LOAD_CYC, 1);
  localparam int unsigned MAX_LEN  = umax(umax(umax(HIGH_LEN, HOLD_LEN), umax(SET_LEN, LEAD_LEN)), LOAD_LEN);
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);
  localparam int unsigned BIT_W    = $clog2(WORD_W + 1);

  localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_LEN - 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_LEN - 1);
  localparam logic [CNT_W-1:0] SET_V  = CNT_W'(SET_LEN - 1);
  localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD_LEN - 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD_LEN - 1);

  seq_state_t       state;
  logic [BIT_W-1:0] bits_left;
  logic             sclk_q, load_n_q, ready_q;
  logic             tmr_ld, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift;
  logic [WORD_W-1:0] mapped;
  logic             last_bit;

  assign last_bit = (bits_left == '0);

  dac_code_map #(.WORD_W(WORD_W)) u_map (
    .bipolar (in_bipolar),
    .code_in (in_code),
    .code_out(mapped)
  );

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk (clk),
    .rst (rst),
    .ld  (tmr_ld),
    .val (tmr_val),
    .done(tmr_done)
  );

  dac_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (sh_load),
    .din  (mapped),
    .shift(sh_shift),
    .msb  (sdata)
  );

  // timer reload and shifter control at each phase boundary
  always_comb begin
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state)
      ST_IDLE: if (in_valid) begin
        tmr_ld  = 1'b1;
        tmr_val = LEAD_V;
        sh_load = 1'b1;
      end
      ST_LEAD, ST_LOWSET: if (tmr_done) begin
        tmr_ld  = 1'b1;
        tmr_val = HIGH_V;
      end
      ST_HIGH: if (tmr_done) begin
        tmr_ld  = 1'b1;
        tmr_val = last_bit ? LOAD_V : HOLD_V;
      end
      ST_LOWHOLD: if (tmr_done) begin
        tmr_ld   = 1'b1;
        tmr_val  = SET_V;
        sh_shift = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bits_left <= '0;
      sclk_q    <= 1'b0;
      load_n_q  <= 1'b1;
      ready_q   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state     <= ST_LEAD;
          ready_q   <= 1'b0;
          bits_left <= BIT_W'(WORD_W - 1);
        end
        ST_LEAD, ST_LOWSET: if (tmr_done) begin
          sclk_q <= 1'b1;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (tmr_done) begin
          sclk_q <= 1'b0;
          if (last_bit) begin
            load_n_q <= 1'b0;
            state    <= ST_LOAD;
          end else begin
            state    <= ST_LOWHOLD;
          end
        end
        ST_LOWHOLD: if (tmr_done) begin
          bits_left <= bits_left - 1'b1;
          state     <= ST_LOWSET;
        end
        ST_LOAD: if (tmr_done) begin
          load_n_q <= 1'b1;
          ready_q  <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk     = sclk_q;
  assign load_n   = load_n_q;
  assign in_ready = ready_q;

endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker #(
  parameter int unsigned HIGH_CYC = 9
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic sdata,
  input logic load_n
);
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst || !sclk)         hi_run <= '0;
    else if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
  end

  // R1: acceptance drops ready on the next cycle
  a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R1: no acceptance while the word is moving or loading
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (sclk || !load_n) |-> !in_ready);

  // R1: ready returns with the end of the load pulse
  a_r1_ready_back: assert property (@(posedge clk) disable iff (rst)
    $rose(load_n) |-> in_ready);

  // R5: data moves only inside a clock-low stretch
  a_r5_data_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> (!sclk && !$past(sclk)));

  // R7: minimum clock-high width
  a_r7_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_run >= 16'(HIGH_CYC)));

  // R8: load pulse begins as the last high phase ends, clock low throughout
  a_r8_load_after_high: assert property (@(posedge clk) disable iff (rst)
    $fell(load_n) |-> ($past(sclk) && !sclk));

  a_r8_clock_low_in_load: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> !sclk);

  // R10: reset forces the idle outputs
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!sclk && load_n && in_ready && !sdata));

endmodule

bind dac_serial_loader dac_seq_checker #(.HIGH_CYC(HIGH_CYC)) u_seq_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .sclk    (sclk),
  .sdata   (sdata),
  .load_n  (load_n)
);

// File: tb/test_dac_serial_loader.sv
module test_dac_serial_loader;
  localparam int unsigned W     = 12;
  localparam int unsigned SETUP = 4;
  localparam int unsigned HOLD  = 8;
  localparam int unsigned HIGH  = 9;
  localparam int unsigned LOW   = 12;
  localparam int unsigned LOAD  = 12;

  // {bipolar, code, expected transmitted word}
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 12'hABC, 12'hABC},
    {1'b0, 12'h000, 12'h000},
    {1'b0, 12'hFFF, 12'hFFF},
    {1'b0, 12'h001, 12'h001},
    {1'b0, 12'h800, 12'h800},
    {1'b1, 12'h800, 12'h000},
    {1'b1, 12'h7FF, 12'hFFF},
    {1'b1, 12'h000, 12'h800},
    {1'b1, 12'hFFF, 12'h7FF},
    {1'b1, 12'h555, 12'hD55},
    {1'b0, 12'h5A3, 12'h5A3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_code = '0;
  logic in_bipolar = 1'b0;
  logic sclk, sdata, load_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  dac_serial_loader #(
    .WORD_W(W), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
    .HIGH_CYC(HIGH), .LOW_CYC(LOW), .LOAD_CYC(LOAD)
  ) i_dac_serial_loader (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_bipolar(in_bipolar),
    .sclk(sclk), .sdata(sdata), .load_n(load_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- port monitor, sampled on the falling edge ----------------
  logic prev_sclk = 1'b0, prev_sdata = 1'b0, prev_load_n = 1'b1;
  int run_same = 0, hold_run = 0, hi_run = 0, lo_run = 0, ld_run = 0;
  bit hold_open = 0;
  int cap_bits = 0;
  logic [W-1:0] cap_word = '0;
  int min_setup = 1000000, min_hold = 1000000, min_hi = 1000000;
  int min_lo = 1000000, min_ld = 1000000;
  int bad_change = 0, bad_busy = 0, bad_back = 0;
  int n_done = 0;
  logic [W-1:0] words [64];
  int bits [64];

  always @(negedge clk) begin
    if (rst) begin
      hold_open = 0; cap_bits = 0; cap_word = '0; run_same = 0;
    end else begin
      if (sdata != prev_sdata) begin
        if (sclk || prev_sclk) bad_change++;
        if (hold_open && hold_run < min_hold) min_hold = hold_run;
        hold_open = 0;
        run_same = 1;
      end else begin
        run_same++;
        if (hold_open) hold_run++;
      end
      if (sclk && !prev_sclk) begin
        if (run_same - 1 < min_setup) min_setup = run_same - 1;
        if (cap_bits > 0 && lo_run < min_lo) min_lo = lo_run;
        hold_open = 1; hold_run = 1; hi_run = 1;
        cap_word = {cap_word[W-2:0], sdata};
        cap_bits++;
      end else if (sclk) begin
        hi_run++;
      end else if (prev_sclk) begin
        if (hi_run < min_hi) min_hi = hi_run;
        lo_run = 1;
      end else begin
        lo_run++;
      end
      if (!load_n) begin
        if (prev_load_n) ld_run = 1; else ld_run++;
      end else if (!prev_load_n) begin
        if (ld_run < min_ld) min_ld = ld_run;
        if (!in_ready) bad_back++;
        words[n_done % 64] = cap_word;
        bits[n_done % 64]  = cap_bits;
        n_done++;
        cap_bits = 0; cap_word = '0;
      end
      if ((sclk || !load_n) && in_ready) bad_busy++;
    end
    prev_sclk = sclk; prev_sdata = sdata; prev_load_n = load_n;
  end

  // offer a code; after acceptance scramble the inputs (R4)
  task automatic send(input logic bip, input logic [W-1:0] code);
    @(negedge clk);
    in_valid = 1'b1; in_code = code; in_bipolar = bip;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_code = ~code; in_bipolar = ~bip;
    chk(in_ready == 1'b0, "R1 ready low after accept", in_ready, 0);
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(sclk == 1'b0 && load_n == 1'b1 && in_ready == 1'b1 && sdata == 1'b0,
        "R10 reset state", {sclk, load_n, in_ready, sdata}, 4'b0110);
    rst = 1'b0;

    // table of codes, both modes
    for (int i = 0; i < NV; i++) begin
      int base;
      base = n_done;
      send(VEC[i][24], VEC[i][23:12]);
      wait_done(base + 1);
      chk(bits[base % 64] == W, "R2 bit count", bits[base % 64], W);
      chk(words[base % 64] == VEC[i][11:0], VEC[i][24] ? "R3 bipolar word" : "R2 word/R4 latched",
          words[base % 64], VEC[i][11:0]);
      chk(in_ready == 1'b1, "R7 idle ready", in_ready, 1);
    end
    chk(sclk == 1'b0, "R7 clock idles low", sclk, 0);

    // R9: second word offered during a transfer
    begin
      int base;
      base = n_done;
      @(negedge clk);
      in_valid = 1'b1; in_code = 12'h3C5; in_bipolar = 1'b0;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_code = 12'h9A6; in_bipolar = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      wait_done(base + 2);
      chk(words[base % 64] == 12'h3C5, "R9 first word", words[base % 64], 12'h3C5);
      chk(words[(base + 1) % 64] == 12'h1A6, "R9 held word", words[(base + 1) % 64], 12'h1A6);
      chk(bits[(base + 1) % 64] == W, "R9 held bits", bits[(base + 1) % 64], W);
    end

    // R10: reset in the middle of a word
    begin
      int base;
      base = n_done;
      send(1'b0, 12'hF0F);
      repeat (100) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b0 && load_n == 1'b1 && in_ready == 1'b1 && sdata == 1'b0,
          "R10 mid-transfer reset", {sclk, load_n, in_ready, sdata}, 4'b0110);
      @(negedge clk);
      rst = 1'b0;
      repeat (600) @(negedge clk);
      chk(n_done == base, "R10 no load after abort", n_done, base);
      send(1'b0, 12'h123);
      wait_done(base + 1);
      chk(words[base % 64] == 12'h123, "R10 word after reset", words[base % 64], 12'h123);
    end

    // timing minima over all transfers
    chk(min_setup >= SETUP, "R5 setup", min_setup, SETUP);
    chk(bad_change == 0, "R5 data moves only while low", bad_change, 0);
    chk(min_hold >= HOLD, "R6 hold", min_hold, HOLD);
    chk(min_hi >= HIGH, "R7 high width", min_hi, HIGH);
    chk(min_lo >= LOW, "R7 low width", min_lo, LOW);
    chk(min_ld >= LOAD, "R8 load width", min_ld, LOAD);
    chk(bad_busy == 0, "R1 ready low while busy", bad_busy, 0);
    chk(bad_back == 0, "R1 ready back with load end", bad_back, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule